// File: doc/BRIEF.md
# Serial Register Transport Engine

This block moves one 16-bit register value at a time between the local logic and an external device over a one-bit serial link with a chip select. The local side offers a request: an 8-bit register address, a direction flag and, for writes, 16 bits of data. The engine then runs one serial frame and reports completion with a single-cycle done pulse. On reads, the captured register value comes back with that pulse.

A frame always starts with the register address, followed by one direction bit. A read then leaves one idle turnaround tick so the device can start driving its output, and captures 16 data bits. A write puts its 16 data bits straight after the direction bit. The serial clock is an enable-divided copy of the system clock, and it stays low whenever the chip select is inactive. The frame is short enough that a read, from acceptance to done, fits inside a fixed window of 80 system clocks. That window is one slow read cycle of an attached processor bus, so the engine can serve such a read without stalling the bus.

Top module: `reg_link_master`

## Requirements
- R1: After reset, `req_ready` is 1, `ser_cs_n` is 1, `ser_clk` is 0 and `done` is 0.
- R2: Each frame carries the register address on its first 8 serial ticks, most significant bit first. The device samples `ser_mosi` on each rising edge of `ser_clk`.
- R3: The 9th tick carries the direction bit: 1 for a read, 0 for a write.
- R4: A read frame has 26 ticks. Tick 10 is an idle turnaround. Ticks 11 to 26 sample `ser_miso` on the rising edge of `ser_clk`, most significant bit first, and the result is presented on `rd_data`.
- R5: A write frame has 25 ticks. Ticks 10 to 25 carry `req_wdata`, most significant bit first.
- R6: `ser_mosi` changes only while `ser_clk` is low, so it is stable through every high phase. `ser_clk` stays low while `ser_cs_n` is high.
- R7: `done` is high for exactly one system clock per frame. It rises in the same cycle that `ser_cs_n` returns high. For a read, `rd_data` already holds the captured word in that cycle.
- R8: `ser_cs_n` stays low for the whole frame. Between frames it stays high for at least one full serial tick (2*HALF_DIV system clocks). `req_ready` is 1 only when the engine is idle.
- R9: A request presented while `req_ready` is 0 is ignored: it starts no frame and does not change the frame in progress.
- R10: With default parameters, `done` for a read arrives fewer than 80 system clocks after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; accepted in a cycle where req_ready is 1 |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Engine idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Word captured by the last read |
| ser_clk | output | 1 | Serial clock, idle low |
| ser_cs_n | output | 1 | Active-low frame select |
| ser_mosi | output | 1 | Serial data to the device |
| ser_miso | input | 1 | Serial data from the device |

## Verification
The bench models the device. It decodes each frame edge by edge, and it drives read data on falling serial edges from a register array. This exposes an engine that drops or adds the turnaround tick: the read word would come back shifted by one bit, and the tick count would be 25 or 27. Writes and reads of all-zero, all-one and edge-bit patterns at the lowest and highest addresses catch bit-order reversal, and they catch a direction bit sent with the wrong polarity, which would corrupt the device's array. A request held high through a busy frame would, in a faulty engine, restart or alter the frame or write a second register. The bench also measures the select gap and the done timing, to catch a missing release between frames and a pulse that is too long or too early.

// File: rtl/reg_link_pkg.sv
// Shared definitions for the serial register transport engine.
// Assumes: frame layout is address, direction bit, optional turnaround, data.
package reg_link_pkg;

    typedef enum logic [1:0] {
        LINK_IDLE  = 2'd0,
        LINK_SHIFT = 2'd1,
        LINK_GAP   = 2'd2
    } link_state_e;

    // Number of serial ticks in one frame for the given sizes and direction.
    function automatic int frame_ticks(input int addr_w, input int data_w, input logic is_read);
        return addr_w + 1 + (is_read ? 1 : 0) + data_w;
    endfunction

endpackage

// File: rtl/reg_link_clkgen.sv
// Serial clock generator: divides the system clock by 2*HALF_DIV while run is high.
// Produces one-cycle enables ahead of each serial edge; parks low when run is low.
// Assumes: HALF_DIV >= 1.
module reg_link_clkgen #(
    parameter int HALF_DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk_q,
    output logic rise_en,
    output logic fall_en
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [DIV_W-1:0] div_q;
    logic             at_end;

    assign at_end  = (div_q == DIV_W'(HALF_DIV - 1));
    assign rise_en = run && at_end && !sclk_q;
    assign fall_en = run && at_end && sclk_q;

    // Half-period counter and serial clock phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q  <= '0;
            sclk_q <= 1'b0;
        end else if (at_end) begin
            div_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            div_q  <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/reg_link_shifter.sv
// Serial datapath: outgoing frame shift register and incoming data capture.
// Outgoing bits leave MSB first and advance on falling-edge enables.
// Incoming bits enter LSB side on rising-edge capture enables.
module reg_link_shifter #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_rd,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift_en,
    input  logic              capture_en,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_data
);
    localparam int TX_W = ADDR_W + 2 + DATA_W;

    logic [TX_W-1:0]   tx_q;
    logic [TX_W-1:0]   tx_init;
    logic [DATA_W-1:0] rx_q;

    // Frame image: read carries a turnaround slot, write carries data plus a pad bit.
    always_comb begin
        if (load_rd) tx_init = {load_addr, 1'b1, 1'b0, {DATA_W{1'b0}}};
        else         tx_init = {load_addr, 1'b0, load_data, 1'b0};
    end

    // Outgoing shift register.
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_q <= '0;
        else if (load)     tx_q <= tx_init;
        else if (shift_en) tx_q <= {tx_q[TX_W-2:0], 1'b0};
    end

    // Incoming capture register, holds its value between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)          rx_q <= '0;
        else if (capture_en) rx_q <= {rx_q[DATA_W-2:0], miso};
    end

    assign mosi    = tx_q[TX_W-1];
    assign rx_data = rx_q;

endmodule

// File: rtl/reg_link_ctrl.sv
// Frame sequencer: accepts a request when idle, counts serial ticks,
// steers capture to the data phase of reads, ends the frame and enforces
// one serial tick of deselect before returning to idle.
module reg_link_ctrl
    import reg_link_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_read,
    input  logic rise_en,
    input  logic fall_en,
    output logic ready,
    output logic run,
    output logic active,
    output logic load,
    output logic shift_en,
    output logic capture_en,
    output logic cs_n,
    output logic done
);
    localparam int RD_TICKS   = frame_ticks(ADDR_W, DATA_W, 1'b1);
    localparam int WR_TICKS   = frame_ticks(ADDR_W, DATA_W, 1'b0);
    localparam int CNT_W      = $clog2(RD_TICKS + 1);
    localparam int DATA_START = ADDR_W + 2;

    link_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rd_q;
    logic [CNT_W-1:0] frame_len;

    assign frame_len  = rd_q ? CNT_W'(RD_TICKS) : CNT_W'(WR_TICKS);
    assign ready      = (state_q == LINK_IDLE);
    assign run        = (state_q != LINK_IDLE);
    assign active     = (state_q == LINK_SHIFT);
    assign load       = ready && req_valid;
    assign shift_en   = active && fall_en;
    assign capture_en = active && rise_en && rd_q && (cnt_q >= CNT_W'(DATA_START));

    // Frame state, tick counter, select and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LINK_IDLE;
            cnt_q   <= '0;
            rd_q    <= 1'b0;
            cs_n    <= 1'b1;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                LINK_IDLE: begin
                    if (req_valid) begin
                        state_q <= LINK_SHIFT;
                        cnt_q   <= '0;
                        rd_q    <= req_read;
                        cs_n    <= 1'b0;
                    end
                end
                LINK_SHIFT: begin
                    if (rise_en) cnt_q <= cnt_q + 1'b1;
                    if (fall_en && (cnt_q == frame_len)) begin
                        state_q <= LINK_GAP;
                        cs_n    <= 1'b1;
                        done    <= 1'b1;
                    end
                end
                LINK_GAP: begin
                    if (fall_en) state_q <= LINK_IDLE;
                end
                default: state_q <= LINK_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/reg_link_master.sv
// Serial register transport engine top: runs one address/direction/data
// frame per accepted request over a clock, select and two data lines.
// Assumes: one request at a time; the device drives ser_miso on falling edges.
module reg_link_master #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int HALF_DIV = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_read,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              ser_clk,
    output logic              ser_cs_n,
    output logic              ser_mosi,
    input  logic              ser_miso
);
    logic run, active, load, shift_en, capture_en;
    logic sclk_q, rise_en, fall_en;

    reg_link_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_read   (req_read),
        .rise_en    (rise_en),
        .fall_en    (fall_en),
        .ready      (req_ready),
        .run        (run),
        .active     (active),
        .load       (load),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .cs_n       (ser_cs_n),
        .done       (done)
    );

    reg_link_clkgen #(.HALF_DIV(HALF_DIV)) i_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .sclk_q  (sclk_q),
        .rise_en (rise_en),
        .fall_en (fall_en)
    );

    reg_link_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_rd    (req_read),
        .load_addr  (req_addr),
        .load_data  (req_wdata),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .miso       (ser_miso),
        .mosi       (ser_mosi),
        .rx_data    (rd_data)
    );

    // Serial clock reaches the pin only inside a frame; the gap tick stays internal.
    assign ser_clk = sclk_q && active;

endmodule

// File: rtl/reg_link_master_chk.sv
// Protocol checker for reg_link_master, attached by bind.
// Watches only the top-level ports and keeps its own counters.
module reg_link_master_chk #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int HALF_DIV    = 1,
    parameter int READ_WINDOW = 80
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_read,
    input logic req_ready,
    input logic done,
    input logic ser_clk,
    input logic ser_cs_n,
    input logic ser_mosi
);
    logic [15:0] gap_cnt;
    logic [15:0] win_cnt;
    logic        win_on;
    logic [7:0]  tick_cnt;
    logic        rd_lat;
    logic        clk_prev;
    logic        accept;

    assign accept = req_valid && req_ready;

    // Deselect length, saturating; starts saturated so the first frame passes.
    always_ff @(posedge clk) begin
        if (!rst_n)                gap_cnt <= 16'hFFFF;
        else if (!ser_cs_n)        gap_cnt <= '0;
        else if (gap_cnt != 16'hFFFF) gap_cnt <= gap_cnt + 1'b1;
    end

    // Read latency window and per-frame tick counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt  <= '0;
            win_on   <= 1'b0;
            tick_cnt <= '0;
            rd_lat   <= 1'b0;
            clk_prev <= 1'b0;
        end else begin
            clk_prev <= ser_clk;
            if (accept) begin
                win_cnt  <= '0;
                win_on   <= req_read;
                tick_cnt <= '0;
                rd_lat   <= req_read;
            end else begin
                if (done) win_on <= 1'b0;
                else if (win_on) win_cnt <= win_cnt + 1'b1;
                if (ser_clk && !clk_prev) tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

    a_r1_ready_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> ser_cs_n);
    a_r6_clk_parked: assert property (@(posedge clk) disable iff (!rst_n)
        ser_cs_n |-> !ser_clk);
    a_r6_mosi_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_cs_n && ser_clk && $past(ser_clk)) |-> $stable(ser_mosi));
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ser_cs_n && !$past(ser_cs_n)));
    a_r8_gap_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_cs_n) |-> (gap_cnt >= 16'(2 * HALF_DIV)));
    a_r4_read_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rd_lat) |-> (tick_cnt == 8'(ADDR_W + 2 + DATA_W)));
    a_r5_write_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rd_lat) |-> (tick_cnt == 8'(ADDR_W + 1 + DATA_W)));
    a_r10_read_window: assert property (@(posedge clk) disable iff (!rst_n)
        win_on |-> (win_cnt < 16'(READ_WINDOW)));

endmodule

bind reg_link_master reg_link_master_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .HALF_DIV (HALF_DIV)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_read  (req_read),
    .req_ready (req_ready),
    .done      (done),
    .ser_clk   (ser_clk),
    .ser_cs_n  (ser_cs_n),
    .ser_mosi  (ser_mosi)
);

// File: tb/test_reg_link_master.sv
// Directed bench for reg_link_master with a behavioural serial device model.
module test_reg_link_master;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int RD_TICKS = AW + 2 + DW;
    localparam int WR_TICKS = AW + 1 + DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_read = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, done;
    logic [DW-1:0] rd_data;
    logic          ser_clk, ser_cs_n, ser_mosi;
    logic          ser_miso = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_link_master i_reg_link_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rd_data(rd_data), .ser_clk(ser_clk), .ser_cs_n(ser_cs_n),
        .ser_mosi(ser_mosi), .ser_miso(ser_miso)
    );

    // ---------------- device model ----------------
    logic [DW-1:0] dev_mem [0:255];
    logic          fbits [0:31];
    int            rcnt = 0;
    bit            in_frame = 0;
    int            frames = 0;
    int            last_ticks = 0;
    logic [AW-1:0] last_addr;
    logic          last_rw;
    logic [DW-1:0] last_wdata;

    function automatic logic [AW-1:0] frame_addr();
        logic [AW-1:0] a;
        for (int i = 0; i < AW; i++) a[AW-1-i] = fbits[i];
        return a;
    endfunction

    always @(negedge ser_cs_n) begin
        in_frame = 1;
        rcnt = 0;
    end

    always @(posedge ser_clk) begin
        if (!ser_cs_n) begin
            if (rcnt < 32) fbits[rcnt] = ser_mosi;
            rcnt++;
        end
    end

    always @(negedge ser_clk) begin
        #1;
        if (!ser_cs_n && fbits[AW] === 1'b1 && rcnt >= AW + 2 && rcnt < RD_TICKS)
            ser_miso = dev_mem[frame_addr()][RD_TICKS - 1 - rcnt];
    end

    always @(posedge ser_cs_n) begin
        if (in_frame) begin
            in_frame   = 0;
            frames++;
            last_ticks = rcnt;
            last_addr  = frame_addr();
            last_rw    = fbits[AW];
            for (int i = 0; i < DW; i++) last_wdata[DW-1-i] = fbits[AW+1+i];
            if (last_rw === 1'b0 && rcnt == WR_TICKS) dev_mem[last_addr] = last_wdata;
        end
    end

    // ---------------- line monitors, sampled mid-cycle ----------------
    int   mosi_viol = 0, done_viol = 0, gap_min = 1000, gap_run = 0, frames_seen_gap = 0;
    logic prev_clk = 1'b0, prev_mosi = 1'b0, prev_done = 1'b0, prev_cs = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!ser_cs_n && ser_clk && prev_clk && ser_mosi !== prev_mosi) mosi_viol++;
            if (ser_cs_n && ser_clk) mosi_viol++;
            if (done && prev_done) done_viol++;
            if (ser_cs_n) gap_run++;
            if (!ser_cs_n && prev_cs) begin
                if (frames_seen_gap > 0 && gap_run < gap_min) gap_min = gap_run;
                frames_seen_gap++;
                gap_run = 0;
            end
            prev_clk = ser_clk; prev_mosi = ser_mosi; prev_done = done; prev_cs = ser_cs_n;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic rw, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output int lat);
        int guard = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_read = rw; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        lat = 1;
        while (!done && guard < 1000) begin @(negedge clk); lat++; guard++; end
        rd = rd_data;
        check(done === 1'b1 && ser_cs_n === 1'b1, "R7 done with select release",
              {30'd0, done, ser_cs_n}, 32'h3);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        check(req_ready === 1'b1, "R1 ready", req_ready, 1);
        check(ser_cs_n === 1'b1, "R1 cs_n", ser_cs_n, 1);
        check(ser_clk === 1'b0, "R1 sclk", ser_clk, 0);
        check(done === 1'b0, "R1 done", done, 0);
    endtask

    task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] rd; int lat;
        xfer(1'b0, a, d, rd, lat);
        check(last_ticks == WR_TICKS, "R5 write tick count", last_ticks, WR_TICKS);
        check(last_addr === a, "R2 write address", last_addr, a);
        check(last_rw === 1'b0, "R3 write direction", last_rw, 0);
        check(last_wdata === d, "R5 write data", last_wdata, d);
    endtask

    task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] rd; int lat;
        dev_mem[a] = d;
        xfer(1'b1, a, 16'h0, rd, lat);
        check(last_ticks == RD_TICKS, "R4 read tick count", last_ticks, RD_TICKS);
        check(last_addr === a, "R2 read address", last_addr, a);
        check(last_rw === 1'b1, "R3 read direction", last_rw, 1);
        check(fbits[AW+1] === 1'b0, "R4 turnaround tick idle", fbits[AW+1], 0);
        check(rd === d, "R4 read data", rd, d);
        check(lat < 80, "R10 read latency", lat, 80);
    endtask

    task automatic t_busy_ignore();
        int f0 = frames; int guard = 0;
        dev_mem[8'h11] = 16'hC3A5;
        dev_mem[8'h22] = 16'h7777;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_read = 1; req_addr = 8'h11; req_wdata = 0;
        @(negedge clk);
        req_valid = 0;
        repeat (10) @(negedge clk);
        check(req_ready === 1'b0, "R8 ready low in frame", req_ready, 0);
        req_valid = 1; req_read = 0; req_addr = 8'h22; req_wdata = 16'h1234;
        repeat (30) @(negedge clk);
        req_valid = 0;
        while (!done && guard < 1000) begin @(negedge clk); guard++; end
        check(rd_data === 16'hC3A5, "R9 original read unaffected", rd_data, 16'hC3A5);
        repeat (40) @(negedge clk);
        check(frames == f0 + 1, "R9 no extra frame", frames, f0 + 1);
        check(last_addr === 8'h11, "R9 frame address kept", last_addr, 8'h11);
        check(dev_mem[8'h22] === 16'h7777, "R9 busy write dropped", dev_mem[8'h22], 16'h7777);
    endtask

    task automatic t_line_rules();
        check(mosi_viol == 0, "R6 mosi stable while sclk high", mosi_viol, 0);
        check(done_viol == 0, "R7 done single cycle", done_viol, 0);
        check(gap_min >= 2, "R8 deselect gap", gap_min, 2);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) dev_mem[i] = 16'(i * 16'h0101);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_write(8'hA5, 16'h3C96);
        t_read(8'h5A, 16'hBEEF);
        t_write(8'h00, 16'h0000);
        t_write(8'hFF, 16'hFFFF);
        t_write(8'h80, 16'h8001);
        t_read(8'h00, 16'h0001);
        t_read(8'hFF, 16'h8000);
        t_read(8'h01, 16'hFFFF);
        // write then read back through the device
        t_write(8'h3C, 16'h5AA5);
        t_read(8'h3C, dev_mem[8'h3C]);
        check(dev_mem[8'h3C] === 16'h5AA5, "R5 device updated", dev_mem[8'h3C], 16'h5AA5);
        t_busy_ignore();
        t_line_rules();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=0x0 expected=0x1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule